// File: doc/BRIEF.md
# Address-Unit Pipeline Hazard Checker

This block sits beside the decode stage of a 16-bit DSP address generation unit. Each cycle it looks at the instruction now in decode and at the register effect of the instruction decoded just before it. It then chooses one of three outcomes. It can request a single stall cycle, raise an illegal-sequence flag, or let the pair proceed. The previous instruction's effect is held in an internal producer register. While a stall is in progress that register holds a bubble, so an instruction that is held in decode cannot stall a second time on the same producer.

Pointer registers are numbered 0 to 3, with 4 for the stack pointer. The pipeline also has one offset register and one modifier register. A plain write to the offset register is absorbed by a one-cycle stall. A bit-field read-modify-write on the offset register is not absorbed and is flagged. Writes to a pointer or to the modifier register are flagged when the next instruction needs them for address arithmetic. The long-displacement indexed mode and moves that do no address arithmetic never create a hazard.

Top module: `agu_hazard_chk`

## Requirements
- R1: While reset is asserted and just after it, `stall`, `illegal` and `illegal_pc` are all zero.
- R2: When the producer is a plain write (op class 0) to the offset register (dest kind 2) and the valid current instruction uses mode 3 (post-update by offset) or mode 4 (pointer plus offset), `stall` is high in that same cycle and for exactly one cycle. The held instruction then proceeds with no stall and no flag.
- R3: When the producer is a bit-modify (op class 1: set, clear or change) on the offset register and the current instruction uses mode 3 or 4, `illegal` is raised and `stall` stays low.
- R4: A bit-test or bit-branch producer (op class 2 or 3) never causes a stall or a flag, whatever register it names.
- R5: When the producer writes a pointer (dest kind 1, op class 0 or 1) whose index `in_dst_ptr` equals the current `in_ptr`, and the current mode is 1 (post-increment), 2 (post-decrement), 3 or 4, `illegal` is raised. This holds for indices 0 to 4.
- R6: A pointer write whose index differs from the current instruction's pointer causes no stall and no flag.
- R7: Mode 5 (pointer plus 16-bit displacement) never causes a stall or a flag, even right after a write to its own pointer.
- R8: Mode 0 (no address arithmetic) never causes a stall or a flag.
- R9: When the producer writes the modifier register (dest kind 3, op class 0 or 1) and the current instruction uses mode 1 to 4 with `in_use_mod` high, `illegal` is raised. With `in_use_mod` low there is no hazard.
- R10: `illegal` is a registered pulse. It is high for one cycle, in the cycle after the offending instruction, and `illegal_pc` then shows that instruction's address. At all other times `illegal_pc` keeps its value.
- R11: A slot with `in_vld` low never stalls and never flags. As a producer it acts as a bubble, so a hazard needs the two instructions to be back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Decode slot holds a valid instruction |
| in_pc | input | 16 | Address of the instruction in decode |
| in_mode | input | 3 | Addressing mode: 0 none, 1 post-inc, 2 post-dec, 3 post-offset, 4 pointer+offset, 5 pointer+displacement |
| in_ptr | input | 3 | Pointer used by the addressing mode (0..3, 4 = stack pointer) |
| in_use_mod | input | 1 | Address update applies the modifier register |
| in_dst_kind | input | 2 | Register written: 0 none, 1 pointer, 2 offset, 3 modifier |
| in_dst_ptr | input | 3 | Pointer index written when dest kind is 1 |
| in_op_cls | input | 2 | Write class: 0 plain write, 1 bit-modify, 2/3 bit-test or bit-branch |
| stall | output | 1 | Insert one stall cycle; decode holds its instruction |
| illegal | output | 1 | One-cycle flag for an illegal pair |
| illegal_pc | output | 16 | Address of the most recently flagged instruction |

## Verification
The assertions assume that the surrounding pipeline obeys the stall. When `stall` is high, the same instruction must be presented again, with identical fields, in the next cycle. The one-stall-per-producer property depends on this. The bench driver follows the rule by construction: whenever its own model predicts a stall, it re-issues the unchanged instruction on the next negative edge. The assertions also assume that the decoded fields are stable between negative edges, and the bench meets this by driving all inputs only at those edges.

// File: rtl/agu_hz_pkg.sv
package agu_hz_pkg;

  typedef enum logic [2:0] {
    AM_PLAIN    = 3'd0,
    AM_POST_INC = 3'd1,
    AM_POST_DEC = 3'd2,
    AM_POST_OFS = 3'd3,
    AM_IDX_OFS  = 3'd4,
    AM_IDX_LONG = 3'd5
  } amode_e;

  typedef enum logic [1:0] {
    DK_NONE = 2'd0,
    DK_PTR  = 2'd1,
    DK_OFS  = 2'd2,
    DK_MOD  = 2'd3
  } dkind_e;

  typedef enum logic [1:0] {
    OC_WRITE   = 2'd0,
    OC_BITMOD  = 2'd1,
    OC_BITTEST = 2'd2,
    OC_BITBR   = 2'd3
  } opcls_e;

  typedef struct packed {
    dkind_e kind;
    opcls_e cls;
  } prod_t;

  localparam prod_t PROD_BUBBLE = '{kind: DK_NONE, cls: OC_BITTEST};

endpackage

// File: rtl/agu_hz_mode_dec.sv
module agu_hz_mode_dec
  import agu_hz_pkg::*;
(
  input  logic       vld,
  input  logic [2:0] mode,
  input  logic       use_mod,
  output logic       need_arith,
  output logic       need_ofs,
  output logic       need_mod
);

  amode_e mode_e;

  always_comb begin
    mode_e     = amode_e'(mode);
    need_arith = 1'b0;
    need_ofs   = 1'b0;
    unique case (mode_e)
      AM_POST_INC, AM_POST_DEC: need_arith = vld;
      AM_POST_OFS, AM_IDX_OFS: begin
        need_arith = vld;
        need_ofs   = vld;
      end
      default: begin
        need_arith = 1'b0;
        need_ofs   = 1'b0;
      end
    endcase
    need_mod = need_arith & use_mod;
  end

endmodule

// File: rtl/agu_hz_producer.sv
module agu_hz_producer
  import agu_hz_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [1:0]       dst_kind,
  input  logic [1:0]       op_cls,
  input  logic [PTR_W-1:0] dst_ptr,
  output prod_t            prod_q,
  output logic [PTR_W-1:0] prod_ptr_q
);

  prod_t            prod_d;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    if (take) begin
      prod_d = '{kind: dkind_e'(dst_kind), cls: opcls_e'(op_cls)};
    end else begin
      prod_d = PROD_BUBBLE;
    end
    ptr_en = take & (dkind_e'(dst_kind) == DK_PTR);
    ptr_d  = dst_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= PROD_BUBBLE;
    end else begin
      prod_q <= prod_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_ptr_q <= '0;
    end else if (ptr_en) begin
      prod_ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/agu_hz_rules.sv
module agu_hz_rules
  import agu_hz_pkg::*;
#(
  parameter int PTR_W   = 3,
  parameter int NUM_PTR = 5
) (
  input  prod_t            prod,
  input  logic [PTR_W-1:0] prod_ptr,
  input  logic [PTR_W-1:0] cur_ptr,
  input  logic             need_arith,
  input  logic             need_ofs,
  input  logic             need_mod,
  output logic             hz_stall,
  output logic             hz_illegal
);

  logic [NUM_PTR-1:0] prod_sel;
  logic [NUM_PTR-1:0] cur_sel;
  logic               same_ptr;
  logic               is_write;
  logic               ofs_stall;
  logic               ofs_ill;
  logic               ptr_ill;
  logic               mod_ill;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr_match
    assign prod_sel[g] = (prod_ptr == PTR_W'(g));
    assign cur_sel[g]  = (cur_ptr  == PTR_W'(g));
  end

  always_comb begin
    same_ptr   = |(prod_sel & cur_sel);
    is_write   = (prod.cls == OC_WRITE) || (prod.cls == OC_BITMOD);
    ofs_stall  = (prod.kind == DK_OFS) && (prod.cls == OC_WRITE)  && need_ofs;
    ofs_ill    = (prod.kind == DK_OFS) && (prod.cls == OC_BITMOD) && need_ofs;
    ptr_ill    = (prod.kind == DK_PTR) && is_write && need_arith && same_ptr;
    mod_ill    = (prod.kind == DK_MOD) && is_write && need_mod;
    hz_illegal = ofs_ill | ptr_ill | mod_ill;
    hz_stall   = ofs_stall & ~hz_illegal;
  end

endmodule

// File: rtl/agu_hz_flag_reg.sv
module agu_hz_flag_reg #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hz_illegal,
  input  logic [PC_W-1:0] cur_pc,
  output logic            illegal_q,
  output logic [PC_W-1:0] illegal_pc_q
);

  logic            flag_d;
  logic            pc_en;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    flag_d = hz_illegal;
    pc_en  = hz_illegal;
    pc_d   = cur_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_pc_q <= '0;
    end else if (pc_en) begin
      illegal_pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/agu_hazard_chk.sv
module agu_hazard_chk
  import agu_hz_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int PTR_W   = 3,
  parameter int NUM_PTR = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [2:0]       in_mode,
  input  logic [PTR_W-1:0] in_ptr,
  input  logic             in_use_mod,
  input  logic [1:0]       in_dst_kind,
  input  logic [PTR_W-1:0] in_dst_ptr,
  input  logic [1:0]       in_op_cls,
  output logic             stall,
  output logic             illegal,
  output logic [PC_W-1:0]  illegal_pc
);

  logic             need_arith;
  logic             need_ofs;
  logic             need_mod;
  logic             hz_stall;
  logic             hz_illegal;
  logic             take;
  prod_t            prod_q;
  logic [PTR_W-1:0] prod_ptr_q;

  agu_hz_mode_dec u_dec (
    .vld        (in_vld),
    .mode       (in_mode),
    .use_mod    (in_use_mod),
    .need_arith (need_arith),
    .need_ofs   (need_ofs),
    .need_mod   (need_mod)
  );

  assign take = in_vld & ~hz_stall;

  agu_hz_producer #(.PTR_W(PTR_W)) u_prod (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .dst_kind   (in_dst_kind),
    .op_cls     (in_op_cls),
    .dst_ptr    (in_dst_ptr),
    .prod_q     (prod_q),
    .prod_ptr_q (prod_ptr_q)
  );

  agu_hz_rules #(.PTR_W(PTR_W), .NUM_PTR(NUM_PTR)) u_rules (
    .prod       (prod_q),
    .prod_ptr   (prod_ptr_q),
    .cur_ptr    (in_ptr),
    .need_arith (need_arith),
    .need_ofs   (need_ofs),
    .need_mod   (need_mod),
    .hz_stall   (hz_stall),
    .hz_illegal (hz_illegal)
  );

  agu_hz_flag_reg #(.PC_W(PC_W)) u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .hz_illegal   (hz_illegal),
    .cur_pc       (in_pc),
    .illegal_q    (illegal),
    .illegal_pc_q (illegal_pc)
  );

  assign stall = hz_stall;

endmodule

// File: rtl/agu_hazard_chk_sva.sv
module agu_hazard_chk_sva #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic [PC_W-1:0] in_pc,
  input logic [2:0]      in_mode,
  input logic            stall,
  input logic            ill_now,
  input logic            illegal,
  input logic [PC_W-1:0] illegal_pc
);

  // R2: the pipeline holds the instruction, so a stall never repeats
  a_r2_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R2: environment assumption, the stalled instruction is re-presented
  a_r2_env_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (in_vld && $stable(in_pc)));

  // R3: a flagged pair never stalls as well
  a_r3_no_stall_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    ill_now |-> !stall);

  // R7: long-displacement mode is exempt
  a_r7_long_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mode == 3'd5) |-> (!stall && !ill_now));

  // R8: no address arithmetic, no hazard
  a_r8_plain_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mode == 3'd0) |-> (!stall && !ill_now));

  // R10: registered pulse carrying the offending address
  a_r10_pulse_pc: assert property (@(posedge clk) disable iff (!rst_n)
    ill_now |=> (illegal && illegal_pc == $past(in_pc)));

  a_r10_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ill_now |=> (!illegal && $stable(illegal_pc)));

  // R11: empty slot is quiet
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> (!stall && !ill_now));

endmodule

bind agu_hazard_chk agu_hazard_chk_sva #(.PC_W(PC_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_vld     (in_vld),
  .in_pc      (in_pc),
  .in_mode    (in_mode),
  .stall      (stall),
  .ill_now    (hz_illegal),
  .illegal    (illegal),
  .illegal_pc (illegal_pc)
);

// File: tb/agu_hazard_chk_bench.sv
module agu_hazard_chk_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [15:0] in_pc;
  logic [2:0]  in_mode;
  logic [2:0]  in_ptr;
  logic        in_use_mod;
  logic [1:0]  in_dst_kind;
  logic [2:0]  in_dst_ptr;
  logic [1:0]  in_op_cls;
  logic        stall;
  logic        illegal;
  logic [15:0] illegal_pc;

  always #5 clk = ~clk;

  agu_hazard_chk u_agu_hazard_chk (.*);

  typedef struct {
    bit          stl;
    bit          ill;
    logic [15:0] pc;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [15:0] last_pc = 16'h0;

  // bench model of the producer
  logic [1:0] m_kind = 2'd0;
  logic [1:0] m_cls  = 2'd2;
  logic [2:0] m_ptr  = 3'd0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic predict(output bit e_stl, output bit e_ill);
    bit arith, ofs, wr;
    arith = in_vld && (in_mode >= 3'd1 && in_mode <= 3'd4);
    ofs   = in_vld && (in_mode == 3'd3 || in_mode == 3'd4);
    wr    = (m_cls == 2'd0 || m_cls == 2'd1);
    e_ill = (m_kind == 2'd2 && m_cls == 2'd1 && ofs) ||
            (m_kind == 2'd1 && wr && arith && m_ptr == in_ptr && in_ptr <= 3'd4) ||
            (m_kind == 2'd3 && wr && arith && in_use_mod);
    e_stl = !e_ill && m_kind == 2'd2 && m_cls == 2'd0 && ofs;
  endtask

  task automatic slot(string req);
    bit s, i;
    exp_t it;
    predict(s, i);
    it.stl = s; it.ill = i; it.pc = in_pc; it.req = req;
    sb.push_back(it);
    if (s || !in_vld) begin
      m_kind = 2'd0; m_cls = 2'd2;
    end else begin
      m_kind = in_dst_kind; m_cls = in_op_cls;
      if (in_dst_kind == 2'd1) m_ptr = in_dst_ptr;
    end
  endtask

  task automatic issue(bit v, logic [15:0] pc, logic [2:0] mode, logic [2:0] ptr,
                       bit um, logic [1:0] dk, logic [2:0] dp, logic [1:0] oc,
                       string req);
    bit s, i;
    @(negedge clk);
    in_vld = v; in_pc = pc; in_mode = mode; in_ptr = ptr; in_use_mod = um;
    in_dst_kind = dk; in_dst_ptr = dp; in_op_cls = oc;
    predict(s, i);
    slot(req);
    if (s) begin
      @(negedge clk);
      slot(req);
    end
  endtask

  // monitor: pops one expected item per driven slot
  initial begin
    exp_t it;
    bit   s_now;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        it    = sb.pop_front();
        s_now = stall;
        @(posedge clk);
        #1;
        chk({it.req, " stall"}, {15'd0, s_now}, {15'd0, it.stl});
        chk({it.req, " illegal"}, {15'd0, illegal}, {15'd0, it.ill});
        if (it.ill) last_pc = it.pc;
        chk({it.req, " illegal_pc"}, illegal_pc, last_pc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_vld = 0; in_pc = 0; in_mode = 0; in_ptr = 0; in_use_mod = 0;
    in_dst_kind = 0; in_dst_ptr = 0; in_op_cls = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 stall", {15'd0, stall}, 16'd0);
    chk("R1 illegal", {15'd0, illegal}, 16'd0);
    chk("R1 illegal_pc", illegal_pc, 16'd0);
    rst_n = 1'b1;

    // R2 plain offset write then post-offset: one stall, then proceed
    issue(1, 16'h0100, 3'd0, 3'd0, 0, 2'd2, 3'd0, 2'd0, "R2 ofs write");
    issue(1, 16'h0101, 3'd3, 3'd2, 0, 2'd0, 3'd0, 2'd0, "R2 post-ofs");
    // R2 pointer+offset mode also stalls
    issue(1, 16'h0102, 3'd0, 3'd0, 0, 2'd2, 3'd0, 2'd0, "R2 ofs write b");
    issue(1, 16'h0103, 3'd4, 3'd1, 0, 2'd0, 3'd0, 2'd0, "R2 idx-ofs");
    // R2 offset write then post-inc: no dependency
    issue(1, 16'h0104, 3'd0, 3'd0, 0, 2'd2, 3'd0, 2'd0, "R2 ofs write c");
    issue(1, 16'h0105, 3'd1, 3'd1, 0, 2'd0, 3'd0, 2'd0, "R2 post-inc no ofs");

    // R3 bit-modify on offset then post-offset: illegal, no stall
    issue(1, 16'h0200, 3'd0, 3'd0, 0, 2'd2, 3'd0, 2'd1, "R3 bitmod ofs");
    issue(1, 16'h0201, 3'd3, 3'd2, 0, 2'd0, 3'd0, 2'd0, "R3 post-ofs");
    issue(1, 16'h0202, 3'd0, 3'd0, 0, 2'd0, 3'd0, 2'd0, "R10 pulse ends");

    // R4 bit-test and bit-branch on offset: no dependency
    issue(1, 16'h0300, 3'd0, 3'd0, 0, 2'd2, 3'd0, 2'd2, "R4 bittest ofs");
    issue(1, 16'h0301, 3'd3, 3'd2, 0, 2'd0, 3'd0, 2'd0, "R4 post-ofs a");
    issue(1, 16'h0302, 3'd0, 3'd0, 0, 2'd2, 3'd0, 2'd3, "R4 bitbr ofs");
    issue(1, 16'h0303, 3'd4, 3'd2, 0, 2'd0, 3'd0, 2'd0, "R4 idx-ofs b");

    // R5 pointer write then post-inc on same pointer
    issue(1, 16'h0400, 3'd0, 3'd0, 0, 2'd1, 3'd2, 2'd0, "R5 write p2");
    issue(1, 16'h0401, 3'd1, 3'd2, 0, 2'd0, 3'd0, 2'd0, "R5 post-inc p2");
    // R5 stack pointer, post-dec
    issue(1, 16'h0402, 3'd0, 3'd0, 0, 2'd1, 3'd4, 2'd0, "R5 write sp");
    issue(1, 16'h0403, 3'd2, 3'd4, 0, 2'd0, 3'd0, 2'd0, "R5 post-dec sp");

    // R6 different pointer
    issue(1, 16'h0500, 3'd0, 3'd0, 0, 2'd1, 3'd1, 2'd0, "R6 write p1");
    issue(1, 16'h0501, 3'd1, 3'd2, 0, 2'd0, 3'd0, 2'd0, "R6 post-inc p2");

    // R7 long displacement exempt
    issue(1, 16'h0600, 3'd0, 3'd0, 0, 2'd1, 3'd1, 2'd0, "R7 write p1");
    issue(1, 16'h0601, 3'd5, 3'd1, 0, 2'd0, 3'd0, 2'd0, "R7 long p1");
    issue(1, 16'h0602, 3'd0, 3'd0, 0, 2'd1, 3'd4, 2'd0, "R7 write sp");
    issue(1, 16'h0603, 3'd5, 3'd4, 1, 2'd0, 3'd0, 2'd0, "R7 long sp");

    // R8 no address arithmetic
    issue(1, 16'h0700, 3'd0, 3'd0, 0, 2'd1, 3'd3, 2'd0, "R8 write p3");
    issue(1, 16'h0701, 3'd0, 3'd3, 0, 2'd0, 3'd0, 2'd0, "R8 plain p3");

    // R9 modifier write
    issue(1, 16'h0800, 3'd0, 3'd0, 0, 2'd3, 3'd0, 2'd0, "R9 write mod");
    issue(1, 16'h0801, 3'd1, 3'd0, 1, 2'd0, 3'd0, 2'd0, "R9 post-inc mod");
    issue(1, 16'h0802, 3'd0, 3'd0, 0, 2'd3, 3'd0, 2'd1, "R9 bitmod mod");
    issue(1, 16'h0803, 3'd1, 3'd1, 0, 2'd0, 3'd0, 2'd0, "R9 no mod use");

    // R11 empty slot separates producer from consumer
    issue(1, 16'h0900, 3'd0, 3'd0, 0, 2'd2, 3'd0, 2'd0, "R11 ofs write");
    issue(0, 16'h0901, 3'd3, 3'd0, 0, 2'd0, 3'd0, 2'd0, "R11 invalid slot");
    issue(1, 16'h0902, 3'd3, 3'd0, 0, 2'd0, 3'd0, 2'd0, "R11 post-ofs late");

    // R10 back-to-back flags update the address
    issue(1, 16'h0A00, 3'd1, 3'd3, 0, 2'd1, 3'd3, 2'd0, "R10 write p3");
    issue(1, 16'h0A01, 3'd1, 3'd3, 0, 2'd1, 3'd3, 2'd0, "R10 first flag");
    issue(1, 16'h0A02, 3'd1, 3'd3, 0, 2'd0, 3'd0, 2'd0, "R10 second flag");
    issue(0, 16'h0000, 3'd0, 3'd0, 0, 2'd0, 3'd0, 2'd0, "R10 hold");

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule